// File: doc/BRIEF.md
# Hertz-Programmed PWM Bank

A bank of sixteen independent pulse-width outputs. Each channel is set by two 16-bit registers. One holds the output frequency in hertz. The other holds the high time as a 16-bit fraction of one period, where 65535 means the whole period. A serial-slave front end writes the registers through a plain address, data and write-strobe port. A combinational read port returns what was last written to any register.

Each channel advances a 32-bit phase accumulator on every system clock. The step is the active frequency multiplied by a step constant, which is computed at elaboration time as round(2^32 / CLK_HZ). The output is high while the upper 16 bits of the phase are below the active duty. New register values wait as pending state. A channel adopts them only when its accumulator wraps, so a running period is never cut short. A channel whose active frequency is 0 is frozen and has no period to protect, so it adopts pending values at once.

Top module: `hz_pwm_bank`

## Requirements
- R1: After a synchronous active-low reset every output is low, every frequency register reads 400 and every duty register reads 0.
- R2: Channel c owns two addresses. The duty register is at address 2c (address bit 0 clear) and the frequency register is at 2c+1 (address bit 0 set). A write changes only the register it addresses.
- R3: With active frequency f, rising edges of the output are 2^32 / (f × step) clock cycles apart.
- R4: Within each period the output is high for the cycles whose phase bits [31:16] are below the active duty. For a duty d that is a multiple of the per-cycle phase step, this is d × period / 65536 cycles.
- R5: An active duty of 0 keeps the output constantly low.
- R6: An active duty of 0xFFFF keeps the output constantly high.
- R7: A written frequency or duty does not affect a running channel before its accumulator wraps. The settings in effect change only on a wrap, or when the active frequency is 0.
- R8: A read returns the last value written to that address, even while the channel still runs on earlier settings.
- R9: An active frequency of 0 freezes the accumulator, and the output holds its level while the duty stays the same. A frozen channel adopts newly written values within three cycles.
- R10: Writes to one channel do not disturb the output of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_addr | input | 5 | Register address for writes and reads |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Last written value at reg_addr (combinational) |
| pwm_out | output | 16 | One pulse output per channel, registered |

## Verification
The properties assume that reset is held low for at least one clock edge before the first write. They also assume that the step constant is nonzero, so that a nonzero frequency always advances the phase and eventually wraps. The stimulus asserts reset for several edges and then drives the strobe, address and data only on falling clock edges, one write per strobe cycle. It uses frequencies that are powers of two, and duties that are multiples of the phase step, so that expected period and high-time counts are exact integers whatever phase offset a change of frequency leaves behind.

// File: rtl/hz_pwm_pkg.sv
`timescale 1ns/1ps
// Shared widths and constants for the hertz-programmed PWM bank.
// Assumes register words and the duty compare share one width.
package hz_pwm_pkg;
    parameter int PWM_DATA_W = 16;
    typedef logic [PWM_DATA_W-1:0] pwm_word_t;
    localparam pwm_word_t DUTY_FULL = '1;
endpackage

// File: rtl/hz_pwm_regfile.sv
`timescale 1ns/1ps
// Pending register file: holds the last written frequency and duty of every
// channel and serves combinational reads.
// Assumes the address is 2*channel + (1 for frequency, 0 for duty).
module hz_pwm_regfile
    import hz_pwm_pkg::*;
#(
    parameter int NUM_CH     = 16,
    parameter int RESET_FREQ = 400,
    localparam int ADDR_W    = $clog2(2 * NUM_CH),
    localparam int CH_W      = ADDR_W - 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  addr,
    input  pwm_word_t                          wdata,
    output pwm_word_t                          rdata,
    output logic [NUM_CH-1:0][PWM_DATA_W-1:0]  pend_freq,
    output logic [NUM_CH-1:0][PWM_DATA_W-1:0]  pend_duty
);
    logic [CH_W-1:0] sel_ch;
    assign sel_ch = addr[ADDR_W-1:1];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_reg
        // Capture a write aimed at this channel into its pending registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_freq[c] <= PWM_DATA_W'(RESET_FREQ);
                pend_duty[c] <= '0;
            end else if (wr_en && sel_ch == CH_W'(c)) begin
                if (addr[0]) pend_freq[c] <= wdata;
                else         pend_duty[c] <= wdata;
            end
        end
    end

    // Return the last written value at the addressed register.
    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (sel_ch == CH_W'(c)) rdata = addr[0] ? pend_freq[c] : pend_duty[c];
        end
    end
endmodule

// File: rtl/hz_pwm_channel.sv
`timescale 1ns/1ps
// One PWM channel: phase accumulator, active settings that load on a wrap
// (or at once while frozen), and a registered duty compare.
// Assumes INC_STEP = round(2^ACC_W / clock rate) and ACC_W >= PWM_DATA_W.
module hz_pwm_channel
    import hz_pwm_pkg::*;
#(
    parameter int              ACC_W      = 32,
    parameter logic [ACC_W-1:0] INC_STEP  = 43,
    parameter int              RESET_FREQ = 400
) (
    input  logic      clk,
    input  logic      rst_n,
    input  pwm_word_t pend_freq,
    input  pwm_word_t pend_duty,
    output pwm_word_t act_freq,
    output pwm_word_t act_duty,
    output logic      wrap,
    output logic      level
);
    logic [ACC_W-1:0] phase_q;
    logic [ACC_W-1:0] inc;
    logic [ACC_W:0]   sum;
    logic             adopt;
    logic             level_d;

    // Step size and carry out of the accumulator for this cycle.
    always_comb begin
        inc   = ACC_W'(act_freq) * INC_STEP;
        sum   = {1'b0, phase_q} + {1'b0, inc};
        wrap  = sum[ACC_W];
        adopt = wrap || (act_freq == '0);
    end

    // Output level from the current phase and active duty.
    always_comb begin
        if (act_duty == DUTY_FULL) level_d = 1'b1;
        else                       level_d = phase_q[ACC_W-1 -: PWM_DATA_W] < act_duty;
    end

    // Advance phase, adopt pending settings on a boundary, register the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= '0;
            act_freq <= PWM_DATA_W'(RESET_FREQ);
            act_duty <= '0;
            level    <= 1'b0;
        end else begin
            phase_q <= sum[ACC_W-1:0];
            if (adopt) begin
                act_freq <= pend_freq;
                act_duty <= pend_duty;
            end
            level <= level_d;
        end
    end
endmodule

// File: rtl/hz_pwm_bank.sv
`timescale 1ns/1ps
// Bank of hertz-programmed PWM channels behind an address/data/strobe port.
// Assumes CLK_HZ is the clock rate and CLK_HZ <= 2^ACC_W.
module hz_pwm_bank
    import hz_pwm_pkg::*;
#(
    parameter int NUM_CH     = 16,
    parameter int ACC_W      = 32,
    parameter int CLK_HZ     = 100_000_000,
    parameter int RESET_FREQ = 400,
    localparam int ADDR_W    = $clog2(2 * NUM_CH),
    localparam logic [63:0] STEP64 = ((64'd1 << ACC_W) + 64'(CLK_HZ / 2)) / 64'(CLK_HZ),
    localparam logic [ACC_W-1:0] INC_STEP = ACC_W'(STEP64)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [PWM_DATA_W-1:0] reg_wdata,
    output logic [PWM_DATA_W-1:0] reg_rdata,
    output logic [NUM_CH-1:0]     pwm_out
);
    logic [NUM_CH-1:0][PWM_DATA_W-1:0] pend_freq;
    logic [NUM_CH-1:0][PWM_DATA_W-1:0] pend_duty;
    logic [NUM_CH-1:0][PWM_DATA_W-1:0] act_freq;
    logic [NUM_CH-1:0][PWM_DATA_W-1:0] act_duty;
    logic [NUM_CH-1:0]                 chan_wrap;

    hz_pwm_regfile #(
        .NUM_CH     (NUM_CH),
        .RESET_FREQ (RESET_FREQ)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .pend_freq (pend_freq),
        .pend_duty (pend_duty)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        hz_pwm_channel #(
            .ACC_W      (ACC_W),
            .INC_STEP   (INC_STEP),
            .RESET_FREQ (RESET_FREQ)
        ) ch_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .pend_freq (pend_freq[c]),
            .pend_duty (pend_duty[c]),
            .act_freq  (act_freq[c]),
            .act_duty  (act_duty[c]),
            .wrap      (chan_wrap[c]),
            .level     (pwm_out[c])
        );
    end
endmodule

// File: rtl/hz_pwm_bank_chk.sv
`timescale 1ns/1ps
// Property checker for the PWM bank, bound to every instance of the top.
// Assumes reset is held for at least one clock edge at start-up.
module hz_pwm_bank_chk
    import hz_pwm_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [NUM_CH-1:0]                 pwm_out,
    input logic [NUM_CH-1:0][PWM_DATA_W-1:0] act_freq,
    input logic [NUM_CH-1:0][PWM_DATA_W-1:0] act_duty,
    input logic [NUM_CH-1:0]                 wrap
);
    // R1
    reset_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pwm_out == '0);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R5
        zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            act_duty[c] == '0 |=> !pwm_out[c]);

        // R6
        full_duty_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            act_duty[c] == DUTY_FULL |=> pwm_out[c]);

        // R7
        hold_until_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!wrap[c] && act_freq[c] != '0) |=> ($stable(act_duty[c]) && $stable(act_freq[c])));

        // R9
        frozen_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (act_freq[c] == '0 && $stable(act_freq[c]) && $stable(act_duty[c])) |=> $stable(pwm_out[c]));
    end
endmodule

bind hz_pwm_bank hz_pwm_bank_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_out  (pwm_out),
    .act_freq (act_freq),
    .act_duty (act_duty),
    .wrap     (chan_wrap)
);

// File: tb/hz_pwm_bank_tb_top.sv
`timescale 1ns/1ps
// Directed bench: CLK_HZ = 2^20, so the step is 4096 and f = 1024 Hz gives a
// 1024-cycle period in which phase bits [31:16] rise by 64 per cycle.
module hz_pwm_bank_tb_top;
    localparam int NUM_CH = 16;
    localparam int CLK_HZ = 1 << 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] pwm_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    hz_pwm_bank #(
        .NUM_CH (NUM_CH),
        .CLK_HZ (CLK_HZ)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input logic [4:0] a, output int d);
        @(negedge clk);
        reg_addr = a;
        #1 d = int'(reg_rdata);
    endtask

    task automatic count_high(input int ch, input int n, output int hi);
        hi = 0;
        repeat (n) begin
            @(negedge clk);
            if (pwm_out[ch]) hi++;
        end
    endtask

    task automatic wait_rise(input int ch);
        logic prev;
        int guard;
        guard = 0;
        @(negedge clk);
        prev = pwm_out[ch];
        while (guard < 10000) begin
            @(negedge clk);
            guard++;
            if (pwm_out[ch] && !prev) break;
            prev = pwm_out[ch];
        end
    endtask

    task automatic measure_period(input int ch, output int per);
        wait_rise(ch);
        per = 0;
        begin
            logic prev;
            prev = pwm_out[ch];
            while (per < 10000) begin
                @(negedge clk);
                per++;
                if (pwm_out[ch] && !prev) break;
                prev = pwm_out[ch];
            end
        end
    endtask

    task automatic test_reset();
        int v;
        check("R1 outputs after reset", int'(pwm_out), 0);
        read_reg(5'd1, v);  check("R1 ch0 frequency", v, 400);
        read_reg(5'd0, v);  check("R1 ch0 duty", v, 0);
        read_reg(5'd31, v); check("R1 ch15 frequency", v, 400);
        count_high(9, 3000, v);
        check("R5 zero duty stays low", v, 0);
    endtask

    task automatic test_map_readback();
        int v;
        write_reg(5'd4, 16'h8000);
        write_reg(5'd5, 16'd1024);
        read_reg(5'd4, v); check("R8 duty readback before effect", v, 16'h8000);
        read_reg(5'd5, v); check("R8 frequency readback", v, 1024);
        read_reg(5'd6, v); check("R2 neighbour duty untouched", v, 0);
        read_reg(5'd7, v); check("R2 neighbour frequency untouched", v, 400);
        read_reg(5'd3, v); check("R2 lower neighbour frequency untouched", v, 400);
    endtask

    task automatic test_period_duty();
        int v;
        wait_cycles(3000);
        measure_period(2, v); check("R3 period at 1024 Hz", v, 1024);
        count_high(2, 1024, v); check("R4 high time duty 0x8000", v, 512);
        write_reg(5'd4, 16'h4000);
        wait_cycles(2100);
        count_high(2, 1024, v); check("R4 high time duty 0x4000", v, 256);
        write_reg(5'd5, 16'd2048);
        wait_cycles(2100);
        measure_period(2, v); check("R3 period at 2048 Hz", v, 512);
        count_high(2, 512, v); check("R4 high time at 2048 Hz", v, 128);
    endtask

    task automatic test_pending();
        int v;
        write_reg(5'd5, 16'd1024);
        write_reg(5'd4, 16'h8000);
        wait_cycles(3000);
        wait_rise(2);
        wait_cycles(10);
        write_reg(5'd4, 16'h0400);
        read_reg(5'd4, v); check("R8 new duty reads back at once", v, 16'h0400);
        wait_cycles(100);
        check("R7 running period keeps old duty", int'(pwm_out[2]), 1);
        wait_cycles(2100);
        count_high(2, 1024, v); check("R7 new duty after wrap", v, 16);
    endtask

    task automatic test_full_duty();
        int v;
        write_reg(5'd14, 16'hFFFF);
        write_reg(5'd15, 16'd1024);
        wait_cycles(3000);
        count_high(7, 2000, v); check("R6 full duty stays high", v, 2000);
    endtask

    task automatic test_freeze();
        int v;
        logic lvl;
        write_reg(5'd5, 16'd0);
        wait_cycles(1100);
        lvl = pwm_out[2];
        count_high(2, 2000, v);
        check("R9 frozen output holds level", v, lvl ? 2000 : 0);
        write_reg(5'd4, 16'hFFFF);
        wait_cycles(3);
        check("R9 frozen channel adopts full duty", int'(pwm_out[2]), 1);
        write_reg(5'd4, 16'h0000);
        wait_cycles(3);
        check("R9 frozen channel adopts zero duty", int'(pwm_out[2]), 0);
        write_reg(5'd4, 16'h8000);
        write_reg(5'd5, 16'd1024);
        wait_cycles(5);
        measure_period(2, v); check("R9 resumes after unfreeze", v, 1024);
    endtask

    task automatic test_independence();
        int v;
        int v4;
        write_reg(5'd6, 16'h8000);
        write_reg(5'd7, 16'd2048);
        wait_cycles(3000);
        fork
            count_high(3, 1024, v);
            count_high(4, 1024, v4);
            begin
                for (int k = 0; k < 40; k++) begin
                    write_reg(5'd10, 16'(k * 1000));
                    write_reg(5'd11, 16'(100 + k));
                end
            end
        join
        check("R10 ch3 unaffected by ch5 writes", v, 512);
        check("R10 ch4 unaffected by ch5 writes", v4, 0);
    endtask

    initial begin
        wait_cycles(5);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_map_readback();
        test_period_duty();
        test_pending();
        test_full_duty();
        test_freeze();
        test_independence();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule